// File: doc/BRIEF.md
# Fractional-N Dual-Modulus Divider Controller

This block runs on the output clock of an external divide-by-10/11 prescaler. It drives that prescaler's modulus-control line and produces the feedback pulse for a phase detector. The main count spans M+1 prescaler periods. During the first A' of those periods it asks for divide-by-11, and for the rest it asks for divide-by-10. A' is the programmed A, plus one whenever a first-order fractional accumulator fed by the word K overflowed at the start of the cycle. The divide ratio seen from the VCO therefore averages 10(M+1)+A+K/2^18.

A bypass input takes the prescaler out of the path. In that case the controller counts M+1 input cycles, leaves the modulus line low and freezes the accumulator, so only integer division is possible. A randomize input injects a constant least significant bit below K into every accumulator step. This breaks up spur patterns at the cost of a small positive frequency offset of 1/2^19 of the comparison frequency.

The sequencer has three states.
- ST_LOAD is entered only from reset. It latches the words for one cycle and issues no pulse.
- ST_SWALLOW is the part of the cycle in which divide-by-11 is requested.
- ST_MAIN is the part of the cycle in which divide-by-10 is requested.

The transitions are:
- load-to-swallow (A' non-zero) or load-to-main (A' zero).
- swallow-to-main, when the last swallow period is reached.
- boundary: at terminal count, from either run state, to swallow or to main according to the A' of the next cycle.

Top module: `fnd_ctrl`

## Requirements
- R1: Consecutive feedback pulses are exactly M+1 clock cycles apart. Each pulse is high for a single clock cycle, in the cycle where the M count reaches its terminal value.
- R2: Within each cycle between pulses, mod_ctrl is high (1 = divide-by-11) for the first min(A', M+1) clock cycles and low for the remainder. It never rises again before the next pulse.
- R3: The fractional accumulator is 18 bits wide, extended by the randomize bit. K is added once per feedback pulse. A carry out raises A' by one for the cycle that begins at that pulse. With K=2^17, the carry occurs on every second addition.
- R4: With rand_en high, each addition adds 2K+1 to a 19-bit accumulator, and the carry is taken from bit 19. With rand_en low, 2K is added.
- R5: M from 1 to 511 is accepted, and M=1 gives a count of 2. An M of 0 is treated as 1.
- R6: A from 0 to 15 is accepted. A'=M+1 keeps mod_ctrl high for the whole cycle.
- R7: With bypass_en high, mod_ctrl stays low and the cycle lasts M+1 clocks. The accumulator neither adds nor changes, and A and K have no effect.
- R8: The inputs m_word, a_word, k_word, bypass_en and rand_en are sampled only at a cycle boundary. A change in the middle of a cycle does not alter the cycle in progress.
- R9: While rst_n is low, both outputs are low. The first cycle after reset is a single ST_LOAD cycle with both outputs low. The first counting cycle then uses A with no fractional carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output clock (VCO clock when bypassed) |
| rst_n | input | 1 | Active-low synchronous reset |
| m_word | input | 9 | Main count value M |
| a_word | input | 4 | Swallow count value A |
| k_word | input | 18 | Fractional word K |
| bypass_en | input | 1 | 1 = prescaler bypassed, integer M+1 division |
| rand_en | input | 1 | 1 = add the extra accumulator LSB |
| mod_ctrl | output | 1 | 1 = prescaler divides by 11, 0 = by 10 |
| fb_pulse | output | 1 | One-cycle feedback pulse to the phase detector |

## Verification
Two pairs of events can fall in the same cycle.
- **Terminal count with the last swallow period.** When A' equals M+1, the swallow-to-main exit and the boundary coincide. The bench provokes this with A=15 and M=14, and with M=1, A=2. It judges the result by checking that mod_ctrl is high for the whole cycle and that the following cycle starts swallowing again.
- **Accumulator carry with a new input word.** At the boundary edge, the accumulator carry lands together with freshly sampled A and M values. The bench changes the words in the middle of a cycle while K=2^17 is producing carries. A reference model, driven only at observed pulses, predicts each cycle's length and swallow count. A total-swallow count over a fixed window confirms the carry rate.

// File: rtl/fnd_pkg.sv
package fnd_pkg;

    typedef enum logic [1:0] {
        ST_LOAD    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2
    } fnd_state_e;

    localparam int FND_M_W = 9;
    localparam int FND_A_W = 4;
    localparam int FND_K_W = 18;

endpackage

// File: rtl/fnd_accum.sv
module fnd_accum #(
    parameter int K_W = 18
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step,
    input  logic [K_W-1:0] k_word,
    input  logic           rand_en,
    output logic           carry_nxt
);
    localparam int ACC_W = K_W + 1;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum_w;

    // The randomize bit sits one place below the K word.
    assign sum_w     = {1'b0, acc_q} + {1'b0, k_word, rand_en};
    assign carry_nxt = sum_w[ACC_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= sum_w[ACC_W-1:0];
        end
    end

    // R3 / R7: the accumulator only moves on an addition step
    assert_acc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(acc_q));

endmodule

// File: rtl/fnd_mcount.sv
module fnd_mcount #(
    parameter int M_W = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [M_W-1:0] m_in,
    output logic [M_W-1:0] cnt_o,
    output logic           tc_o
);
    logic [M_W-1:0] cnt_q;
    logic [M_W-1:0] m_lat_q;
    logic [M_W-1:0] m_safe;

    // A zero M would give a one-cycle period; it is raised to the minimum.
    assign m_safe = (m_in == '0) ? M_W'(1) : m_in;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            m_lat_q <= M_W'(1);
        end else if (load) begin
            cnt_q   <= '0;
            m_lat_q <= m_safe;
        end else begin
            cnt_q <= cnt_q + M_W'(1);
        end
    end

    assign cnt_o = cnt_q;
    assign tc_o  = (cnt_q == m_lat_q);

    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= m_lat_q);

    assert_m_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        m_lat_q != '0);

    assert_hold_m_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(m_lat_q));

endmodule

// File: rtl/fnd_swallow.sv
module fnd_swallow #(
    parameter int M_W = 9,
    parameter int A_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [A_W:0]   a_next,
    input  logic [M_W-1:0] cnt,
    output logic           last_o
);
    localparam int AE_W = A_W + 1;
    localparam int CW   = (M_W + 1 > AE_W) ? M_W + 1 : AE_W;

    logic [AE_W-1:0] a_eff_q;
    logic [CW-1:0]   pos_w;
    logic [CW-1:0]   lim_w;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_eff_q <= '0;
        end else if (load) begin
            a_eff_q <= a_next;
        end
    end

    assign pos_w  = CW'(cnt) + CW'(1);
    assign lim_w  = CW'(a_eff_q);
    assign last_o = (pos_w == lim_w);

    // R6: A' never exceeds the largest A plus one carry
    assert_swallow_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        a_eff_q <= AE_W'(1 << A_W));

endmodule

// File: rtl/fnd_ctrl.sv
module fnd_ctrl
    import fnd_pkg::*;
#(
    parameter int M_W = FND_M_W,
    parameter int A_W = FND_A_W,
    parameter int K_W = FND_K_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [M_W-1:0] m_word,
    input  logic [A_W-1:0] a_word,
    input  logic [K_W-1:0] k_word,
    input  logic           bypass_en,
    input  logic           rand_en,
    output logic           mod_ctrl,
    output logic           fb_pulse
);
    localparam int AE_W = A_W + 1;

    fnd_state_e      state_q, state_d;
    logic [M_W-1:0]  cnt;
    logic            tc;
    logic            last_sw;
    logic            carry_nxt;
    logic            boundary;
    logic            step;
    logic [AE_W-1:0] a_next;
    logic            bypass_q;

    assign boundary = (state_q == ST_LOAD) || tc;
    assign step     = tc && (state_q != ST_LOAD) && !bypass_en;
    assign a_next   = bypass_en ? '0
                    : AE_W'(a_word) + AE_W'(step & carry_nxt);

    fnd_accum #(.K_W(K_W)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .k_word    (k_word),
        .rand_en   (rand_en),
        .carry_nxt (carry_nxt)
    );

    fnd_mcount #(.M_W(M_W)) u_mcount (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (boundary),
        .m_in  (m_word),
        .cnt_o (cnt),
        .tc_o  (tc)
    );

    fnd_swallow #(.M_W(M_W), .A_W(A_W)) u_swallow (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (boundary),
        .a_next (a_next),
        .cnt    (cnt),
        .last_o (last_sw)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_LOAD;
            bypass_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (boundary) begin
                bypass_q <= bypass_en;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD: begin
                state_d = (a_next != '0) ? ST_SWALLOW : ST_MAIN;
            end
            ST_SWALLOW: begin
                if (tc) begin
                    state_d = (a_next != '0) ? ST_SWALLOW : ST_MAIN;
                end else if (last_sw) begin
                    state_d = ST_MAIN;
                end
            end
            ST_MAIN: begin
                if (tc) begin
                    state_d = (a_next != '0) ? ST_SWALLOW : ST_MAIN;
                end
            end
            default: state_d = ST_LOAD;
        endcase
    end

    // Outputs
    always_comb begin
        mod_ctrl = 1'b0;
        fb_pulse = 1'b0;
        unique case (state_q)
            ST_LOAD:    begin mod_ctrl = 1'b0; fb_pulse = 1'b0; end
            ST_SWALLOW: begin mod_ctrl = 1'b1; fb_pulse = tc;   end
            ST_MAIN:    begin mod_ctrl = 1'b0; fb_pulse = tc;   end
            default:    begin mod_ctrl = 1'b0; fb_pulse = 1'b0; end
        endcase
    end

    assert_fb_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |=> !fb_pulse);

    assert_mod_contig_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mod_ctrl && !fb_pulse && state_q != ST_LOAD) |=> !mod_ctrl);

    assert_bypass_nomod_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass_q && state_q != ST_LOAD) |-> !mod_ctrl);

    assert_load_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |-> (!fb_pulse && !mod_ctrl));

endmodule

// File: tb/tb_fnd_ctrl.sv
`timescale 1ns/1ps
module tb_fnd_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  m_word = 9'd3;
    logic [3:0]  a_word = 4'd0;
    logic [17:0] k_word = '0;
    logic        bypass_en = 1'b0;
    logic        rand_en = 1'b0;
    logic        mod_ctrl;
    logic        fb_pulse;

    int checks = 0;
    int errors = 0;
    string tag = "init";

    always #2 clk = ~clk;

    fnd_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .m_word    (m_word),
        .a_word    (a_word),
        .k_word    (k_word),
        .bypass_en (bypass_en),
        .rand_en   (rand_en),
        .mod_ctrl  (mod_ctrl),
        .fb_pulse  (fb_pulse)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s (%s): actual=%0d expected=%0d", req, what, tag, act, exp);
        end
    endtask

    // Reference model of the requirements, advanced at observed pulses
    bit          armed = 0;
    int          len, mc, exp_m, exp_a, tot_mod;
    bit          seen_low, exp_byp;
    logic [18:0] macc;
    logic [19:0] msum;

    function automatic int clamp_m(input int m);
        return (m == 0) ? 1 : m;
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            armed = 0;
        end else if (!armed) begin
            armed = 1;
            // R9: the single load cycle is quiet
            check(fb_pulse == 0 && mod_ctrl == 0, "R9", "load cycle outputs",
                  {fb_pulse, mod_ctrl}, 0);
            exp_m    = clamp_m(int'(m_word));
            exp_byp  = bypass_en;
            exp_a    = bypass_en ? 0 : int'(a_word);
            macc     = '0;
            len = 0; mc = 0; tot_mod = 0; seen_low = 0;
        end else begin
            len++;
            if (mod_ctrl) begin
                mc++;
                tot_mod++;
                if (seen_low) begin
                    check(0, "R2", "mod_ctrl rose after falling", 1, 0);
                end
            end else begin
                seen_low = 1;
            end
            if (fb_pulse) begin
                check(len == exp_m + 1, "R1", "pulse spacing", len, exp_m + 1);
                check(mc == ((exp_a < exp_m + 1) ? exp_a : exp_m + 1), "R2",
                      "swallow cycles", mc, (exp_a < exp_m + 1) ? exp_a : exp_m + 1);
                if (exp_byp) begin
                    check(mc == 0, "R7", "mod_ctrl in bypass", mc, 0);
                end
                // R3 / R4: next cycle's A' from the accumulator model
                exp_m   = clamp_m(int'(m_word));
                exp_byp = bypass_en;
                if (bypass_en) begin
                    exp_a = 0;
                end else begin
                    msum  = {1'b0, macc} + {1'b0, k_word, rand_en};
                    macc  = msum[18:0];
                    exp_a = int'(a_word) + int'(msum[19]);
                end
                len = 0; mc = 0; seen_low = 0;
            end
        end
    end

    task automatic wait_periods(input int n);
        for (int i = 0; i < n; i++) begin
            do @(negedge clk); while (!(fb_pulse && rst_n));
        end
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    // R9: reset state and the first cycle
    task automatic t_reset();
        tag = "reset";
        m_word = 9'd3; a_word = 4'd2; k_word = 18'h3FFFF;
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(fb_pulse == 0, "R9", "fb_pulse in reset", fb_pulse, 0);
        check(mod_ctrl == 0, "R9", "mod_ctrl in reset", mod_ctrl, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        wait_periods(3);
    endtask

    // R1 / R2: integer division with several A values
    task automatic t_integer();
        tag = "integer";
        k_word = '0;
        m_word = 9'd5; a_word = 4'd3; wait_periods(3);
        m_word = 9'd9; a_word = 4'd0; wait_periods(3);
        m_word = 9'd20; a_word = 4'd9; wait_periods(3);
    endtask

    // R5: the smallest M values
    task automatic t_min_m();
        tag = "min_m";
        m_word = 9'd1; a_word = 4'd0; wait_periods(3);
        m_word = 9'd1; a_word = 4'd2; wait_periods(3);
        m_word = 9'd0; a_word = 4'd1; wait_periods(3);
        m_word = 9'd511; a_word = 4'd7; wait_periods(2);
    endtask

    // R3: K = 2^17 carries every second addition
    task automatic t_frac();
        tag = "frac";
        m_word = 9'd9; a_word = 4'd4; k_word = 18'h20000; rand_en = 1'b0;
        do_reset();
        wait_periods(8);
        // 8 cycles of A=4, carries from additions 2, 4 and 6 land in cycles 3, 5, 7
        check(tot_mod == 35, "R3", "swallow total over 8 cycles", tot_mod, 35);
        k_word = 18'h0C000; wait_periods(10);
    endtask

    // R4: randomize bit under the model
    task automatic t_rand();
        tag = "rand";
        m_word = 9'd12; a_word = 4'd5; k_word = 18'h10000; rand_en = 1'b1;
        wait_periods(10);
        k_word = 18'h3FFFF; wait_periods(6);
        rand_en = 1'b0; wait_periods(4);
    endtask

    // R6: largest A, with A' reaching M+1
    task automatic t_max_a();
        tag = "max_a";
        k_word = '0; m_word = 9'd14; a_word = 4'd15;
        do_reset();
        wait_periods(4);
        m_word = 9'd30; a_word = 4'd15; wait_periods(3);
    endtask

    // R7: bypass ignores A and K
    task automatic t_bypass();
        tag = "bypass";
        bypass_en = 1'b1; m_word = 9'd20; a_word = 4'd7; k_word = 18'h3FFFF;
        wait_periods(5);
        bypass_en = 1'b0; m_word = 9'd10; a_word = 4'd2; k_word = 18'h20000;
        wait_periods(4);
    endtask

    // R8: a mid-cycle change waits for the boundary
    task automatic t_update();
        int n;
        tag = "update";
        k_word = '0; m_word = 9'd5; a_word = 4'd2;
        wait_periods(2);
        @(posedge clk); #1;
        m_word = 9'd8; a_word = 4'd6;
        n = 0;
        do begin @(negedge clk); n++; end while (!fb_pulse);
        check(n == 5, "R8", "old M kept after mid-cycle change", n, 5);
        @(posedge clk); #1;
        wait_periods(2);
    endtask

    initial begin
        t_reset();
        t_integer();
        t_min_m();
        t_frac();
        t_rand();
        t_max_a();
        t_bypass();
        t_update();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule